// File: doc/BRIEF.md
# Three-Wire Serial Register Target

This block lets an external controller read and write a bank of 8-bit configuration registers over a three-wire serial link. The link has an active-low select, a serial clock and one shared bidirectional data line. The block runs on the chip's system clock. It brings the three link signals into that clock domain through synchronizer flops, and it detects serial clock edges by oversampling.

Every transaction lasts 24 serial clocks. The first bit is a direction flag: 1 requests a read and 0 requests a write. The next 15 bits carry the register address, most significant bit first. The last 8 bits carry the data byte, most significant bit first. In a write, the controller drives all 24 bits. In a read, the controller drives the first 16 bits and then releases the line. The target then drives the addressed register onto the line, changing bits after falling serial clock edges so the controller can sample them on rising edges.

Top module: `spi_rf_target`

## Requirements
- R1: Incoming bits are sampled on rising serial clock edges only while select is low. Raising select clears the bit counter and shift state, so a transaction aborted at any point leaves the next transaction correctly framed.
- R2: Bit 0 of a frame is the direction flag (1 = read, 0 = write). Bits 1 to 15 form the address, MSB first. Bits 16 to 23 form the data byte, MSB first.
- R3: A write updates the addressed register only after the 24th bit has been sampled, and it updates that register exactly once.
- R4: A read puts the addressed register on the data line MSB first. Each bit changes after a falling serial clock edge and is valid at the next rising edge, for rising edges 17 to 24.
- R5: A read transaction modifies no register.
- R6: The data-line driver is off during the 16 instruction bits and throughout every write. It turns on only in a read, after the last address bit. It turns off once select goes high.
- R7: A write whose select rises before the 24th bit is discarded, and the register keeps its old value.
- R8: Addresses at or above NUM_REGS read back as zero, and writes to them change no register. Upper address bits are not ignored, so there is no aliasing.
- R9: Synchronous active-low reset clears every register to zero.
- R10: Serial clocks beyond the 24th in one select window are ignored. They cause no extra write and no shift of the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sel_n | input | 1 | Active-low transaction select |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_sdio | inout | 1 | Shared serial data line |

## Verification
The bench targets the hand-over of the data line after the 16th bit. If the driver turns on too early, the line shows the register's MSB instead of the pull-up level before the first read fall. If the driver is not released when select rises, the line stays at the last data bit. Truncated writes, and writes followed by extra clocks, separate a design that commits early or repeats a commit from a correct one. An address that differs from a live register only in bit 14 exposes a bank that decodes only the low address bits, because a write to it would overwrite the live register. A read repeated after another read, and a reset issued in the middle of the run, check that reads do not disturb the bank and that reset clears it completely.

// File: rtl/spi_rf_pkg.sv
// Package: shared widths and frame positions for the serial register target.
// Assumes one direction bit, then an address, then one data byte per frame.
package spi_rf_pkg;
    localparam int ADDR_W  = 15;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    // Shift history needed to rebuild the address on its last bit.
    localparam int SH_W    = ADDR_W - 1;

    // Counter value just before the last address bit is sampled.
    localparam logic [CNT_W-1:0] CNT_ADDR_LAST = CNT_W'(ADDR_W);
    // Counter value once the whole instruction has been sampled.
    localparam logic [CNT_W-1:0] CNT_DATA_START = CNT_W'(1 + ADDR_W);
    // Counter value just before the final data bit is sampled.
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/spi_rf_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent. RST_VAL gives the idle level that each
// stage takes on reset, so no false edge appears when reset is released.
module spi_rf_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Later stages: settle metastability one more cycle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rf_framer.sv
// Module: frame decoder and read shifter for the serial link.
// Assumes synchronized inputs, and serial clock half periods of several
// system clocks. Samples data on detected rising edges and launches read data
// on detected falling edges. All framing state clears while select is high.
module spi_rf_framer
    import spi_rf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel_hi,
    input  logic  sck_s,
    input  logic  din_s,
    input  data_t rd_data,
    output addr_t addr_q,
    output logic  wr_en,
    output data_t wr_data,
    output logic  rd_mode,
    output logic  drv_oe,
    output logic  drv_bit,
    output cnt_t  bit_cnt
);
    logic            sck_prev;
    logic            sck_rise;
    logic            sck_fall;
    logic [SH_W-1:0] sh_q;
    data_t           rd_sh_q;
    logic            in_frame;
    logic            in_read_phase;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign sck_rise      = sck_s & ~sck_prev & ~sel_hi;
    assign sck_fall      = ~sck_s & sck_prev & ~sel_hi;
    assign in_frame      = (bit_cnt < CNT_FULL);
    assign in_read_phase = rd_mode && (bit_cnt >= CNT_DATA_START) && in_frame;

    // Count sampled bits, saturating at a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_hi)          bit_cnt <= '0;
        else if (sck_rise && in_frame) bit_cnt <= bit_cnt + 1'b1;
    end

    // Shift in incoming bits MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_hi)          sh_q <= '0;
        else if (sck_rise && in_frame) sh_q <= {sh_q[SH_W-2:0], din_s};
    end

    // Capture the direction flag from the first bit of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_hi)                       rd_mode <= 1'b0;
        else if (sck_rise && bit_cnt == '0)         rd_mode <= din_s;
    end

    // Latch the full address when its last bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_hi)                         addr_q <= '0;
        else if (sck_rise && bit_cnt == CNT_ADDR_LAST) addr_q <= {sh_q, din_s};
    end

    // Issue a single write pulse when the last data bit of a write arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_hi) begin
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else if (sck_rise && bit_cnt == CNT_LAST && !rd_mode) begin
            wr_en   <= 1'b1;
            wr_data <= {sh_q[DATA_W-2:0], din_s};
        end else begin
            wr_en   <= 1'b0;
        end
    end

    // Launch read data on falling edges: load the byte first, then shift.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_hi) begin
            drv_bit <= 1'b0;
            rd_sh_q <= '0;
        end else if (sck_fall && in_read_phase) begin
            if (bit_cnt == CNT_DATA_START) begin
                drv_bit <= rd_data[DATA_W-1];
                rd_sh_q <= {rd_data[DATA_W-2:0], 1'b0};
            end else begin
                drv_bit <= rd_sh_q[DATA_W-1];
                rd_sh_q <= {rd_sh_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    // Enable the line driver at the first read launch; drop it with select.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_hi)                                          drv_oe <= 1'b0;
        else if (sck_fall && in_read_phase && bit_cnt == CNT_DATA_START) drv_oe <= 1'b1;
    end
endmodule

// File: rtl/spi_rf_bank.sv
// Module: bank of NUM_REGS plain storage registers.
// Assumes full-width address decode. Addresses outside the bank read zero and
// ignore writes. Reads are combinational from a held address.
module spi_rf_bank
    import spi_rf_pkg::*;
#(
    parameter int NUM_REGS = 64
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  addr_t addr,
    input  data_t wr_data,
    output data_t rd_data
);
    data_t regs_q [NUM_REGS];

    genvar i;
    generate
        for (i = 0; i < NUM_REGS; i++) begin : g_reg
            // One storage byte: clear on reset, load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)                               regs_q[i] <= '0;
                else if (wr_en && addr == ADDR_W'(i))     regs_q[i] <= wr_data;
            end
        end
    endgenerate

    // Read mux: zero unless an implemented register matches exactly.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (addr == ADDR_W'(k)) rd_data = regs_q[k];
        end
    end
endmodule

// File: rtl/spi_rf_target.sv
// Module: three-wire serial register target (top).
// Assumes the controller runs the serial clock several times slower than clk
// and drives the data line only during instruction and write-data bits.
// The data line is driven only during the data phase of a read.
module spi_rf_target
    import spi_rf_pkg::*;
#(
    parameter int NUM_REGS    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sel_n,
    input  logic spi_sck,
    inout  wire  spi_sdio
);
    // Bundle order: {select_n, serial clock, data}; idle select is high.
    localparam logic [2:0] SYNC_IDLE = 3'b100;

    logic [2:0] sync_v;
    logic       sel_hi;
    logic       sck_s;
    logic       din_s;
    addr_t      addr_q;
    logic       wr_en;
    data_t      wr_data;
    data_t      rd_data;
    logic       rd_mode;
    logic       drv_oe;
    logic       drv_bit;
    cnt_t       bit_cnt;

    spi_rf_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({spi_sel_n, spi_sck, spi_sdio}),
        .sync_out (sync_v)
    );

    assign sel_hi = sync_v[2];
    assign sck_s  = sync_v[1];
    assign din_s  = sync_v[0];

    spi_rf_framer u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_hi  (sel_hi),
        .sck_s   (sck_s),
        .din_s   (din_s),
        .rd_data (rd_data),
        .addr_q  (addr_q),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_mode (rd_mode),
        .drv_oe  (drv_oe),
        .drv_bit (drv_bit),
        .bit_cnt (bit_cnt)
    );

    spi_rf_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr_q),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    // Tri-state driver for the shared data line.
    assign spi_sdio = drv_oe ? drv_bit : 1'bz;
endmodule

// File: rtl/spi_rf_target_chk.sv
// Module: property checker for the serial register target, bound to the top.
// Assumes the framer's counter, direction, write pulse and driver enable.
module spi_rf_target_chk
    import spi_rf_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic sel_hi,
    input logic oe,
    input logic rd_mode,
    input logic wr_en,
    input cnt_t bit_cnt
);
    assert_oe_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> rd_mode);
    assert_oe_after_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (bit_cnt >= CNT_DATA_START));
    assert_oe_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hi |=> !oe);
    assert_wr_full_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (bit_cnt == CNT_FULL));
    assert_no_write_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_mode);
    assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_FULL);
    assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hi |=> (bit_cnt == '0));
endmodule

bind spi_rf_target spi_rf_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_hi  (sel_hi),
    .oe      (drv_oe),
    .rd_mode (rd_mode),
    .wr_en   (wr_en),
    .bit_cnt (bit_cnt)
);

// File: tb/spi_rf_target_bench.sv
`timescale 1ns/1ps
module spi_rf_target_bench;
    localparam int NUM  = 64;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic sck = 1'b0;
    logic tb_oe = 1'b0;
    logic tb_bit = 1'b0;
    tri   spi_sdio;

    pullup (spi_sdio);
    assign spi_sdio = tb_oe ? tb_bit : 1'bz;

    always #2.5 clk = ~clk;

    spi_rf_target #(.NUM_REGS(NUM)) u_spi_rf_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sel_n (sel_n),
        .spi_sck   (sck),
        .spi_sdio  (spi_sdio)
    );

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    logic [7:0] model [NUM];
    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];
    logic       early_level;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: bit-bang one select window of nbits serial clocks.
    task automatic xfer(input bit rw, input logic [14:0] addr, input logic [7:0] wd,
                        input int nbits, output logic [7:0] rbyte);
        logic [23:0] frame;
        frame = {rw, addr, wd};
        rbyte = '0;
        sel_n = 1'b0;
        tb_oe = 1'b1;
        wait_clk(HALF);
        for (int b = 0; b < nbits; b++) begin
            sck = 1'b0;
            if (rw && b >= 16) begin
                if (b == 16) begin
                    tb_oe = 1'b0;
                    #1 early_level = spi_sdio;
                end
            end else begin
                tb_bit = (b < 24) ? frame[23-b] : 1'b1;
            end
            wait_clk(HALF);
            if (rw && b >= 16 && b < 24) rbyte = {rbyte[6:0], spi_sdio};
            sck = 1'b1;
            wait_clk(HALF);
        end
        sck = 1'b0;
        wait_clk(HALF);
        tb_oe = 1'b0;
        sel_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic do_write(input logic [14:0] addr, input logic [7:0] wd, input int nbits);
        logic [7:0] dummy;
        xfer(1'b0, addr, wd, nbits, dummy);
        if (nbits >= 24 && addr < NUM) model[addr] = wd;
    endtask

    // Push the expected byte into the scoreboard, then run the read.
    task automatic do_read(input logic [14:0] addr, input string req);
        logic [7:0] got;
        exp_q.push_back(addr < NUM ? model[addr] : 8'h00);
        tag_q.push_back(req);
        xfer(1'b1, addr, 8'h00, 24, got);
        act_q.push_back(got);
    endtask

    // Monitor: compare read results against the scoreboard as they appear.
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(a == e, t, a, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < NUM; i++) model[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R9: registers start at zero after reset.
        do_read(15'd0,  "R9 reset reg0");
        do_read(15'd1,  "R9 reset reg1");
        do_read(15'd63, "R9 reset reg63");
        check(spi_sdio === 1'b1, "R6 idle line released", spi_sdio, 1);

        // R3 R4 R6: write and read back; line not driven before first fall.
        do_write(15'd3, 8'h5A, 24);
        do_read(15'd3, "R3 R4 readback reg3");
        check(early_level === 1'b1, "R6 no drive before launch", early_level, 1);
        check(spi_sdio === 1'b1, "R6 release after select", spi_sdio, 1);

        // R2: several patterns and addresses, MSB first.
        do_write(15'd0,  8'hA5, 24);
        do_write(15'd63, 8'hFF, 24);
        do_write(15'd32, 8'h01, 24);
        do_read(15'd0,  "R2 pattern A5");
        do_read(15'd63, "R2 pattern FF");
        do_read(15'd32, "R2 pattern 01");

        // R5: reads leave contents unchanged.
        do_read(15'd3, "R5 first read");
        do_read(15'd3, "R5 repeat read");

        // R7: write cut short after 20 bits is dropped.
        do_write(15'd3, 8'hC3, 20);
        do_read(15'd3, "R7 truncated write");

        // R1: abort in the instruction phase, then a clean frame works.
        do_write(15'd4, 8'h99, 10);
        do_write(15'd4, 8'h3C, 24);
        do_read(15'd4, "R1 frame after abort");

        // R8: out-of-range address that aliases reg3 in its low bits.
        do_write(15'h4003, 8'h11, 24);
        do_read(15'd3, "R8 no alias write");
        do_read(15'h4003, "R8 out of range read");
        do_read(15'd64, "R8 first unimplemented");

        // R10: extra clocks after the frame do not alter the write.
        do_write(15'd5, 8'h77, 30);
        do_read(15'd5, "R10 extra clocks");

        // R9: reset mid-run clears the bank.
        wait_clk(2);
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        for (int i = 0; i < NUM; i++) model[i] = 8'h00;
        wait_clk(4);
        do_read(15'd3,  "R9 cleared reg3");
        do_read(15'd63, "R9 cleared reg63");

        wait_clk(10);
        finish_run();
    end
endmodule